// File: doc/BRIEF.md
# Multiplexed-Address DRAM Strobe Sequencer

This block drives a 16K x 8 bank of dynamic RAM whose address pins are shared between row and column. It takes a decoded bank select (active low), the 14-bit CPU address, an active-high read strobe and the CPU's refresh and memory-request strobes (both active low). It produces a 7-bit multiplexed address, active-low row and column strobes, and an active-low write enable.

An access begins when the select goes low. The row strobe falls in the same instant and the row address is already on the bus. On the next rising edge of the CPU clock a first phase flop sets and switches the address mux to the column half. On the following rising edge of the double-rate clock a second phase flop sets and drops the column strobe. Both flops are cleared asynchronously and held clear while the select is high, so releasing the select ends the cycle at once. When the CPU runs a refresh cycle with the bank deselected, the row strobe alone asserts and the refresh address passes through as the row. The double-rate clock runs at twice the CPU clock and is phase-aligned to it.

The phase is decoded from the two flops and the select into four named states. PH_IDLE has the select high and both flops clear. PH_ROW has the select low with neither flop set. PH_COL has the first flop set. PH_CAS has both flops set. The transitions are: PH_IDLE to PH_ROW when the select falls; PH_ROW to PH_COL on a CPU-clock edge; PH_COL to PH_CAS on the next double-rate edge; any state back to PH_IDLE when the select rises or reset asserts.

Top module: `dram_ras_cas_seq`

## Requirements
- R1: While reset is low, both phase flops are clear. With the select high and no refresh, ras_n=1, cas_n=1 and ma equals addr[6:0].
- R2: In PH_IDLE and PH_ROW the multiplexed address ma equals addr[6:0].
- R3: ras_n goes low in the same instant as sel_n goes low, with no clock edge needed.
- R4: On the first rising CPU-clock edge with the select low, ma switches to addr[13:7] and cas_n stays high.
- R5: On the next rising double-rate edge after R4, cas_n goes low. ma holds addr[13:7] and ras_n stays low.
- R6: When sel_n returns high, ras_n and cas_n return high at once and ma returns to addr[6:0].
- R7: With sel_n high and both rfsh_n and mreq_n low, ras_n is low, cas_n stays high across clock edges, and ma equals addr[6:0].
- R8: we_n follows rd: rd=0 (write) gives we_n=0 and rd=1 (read) gives we_n=1.
- R9: cas_n is never low while ras_n is high.
- R10: If sel_n rises before any CPU-clock edge, cas_n never falls and ma never leaves addr[6:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock; steps the first phase flop |
| clk2x | input | 1 | Double-rate clock, phase-aligned; steps the second phase flop |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Decoded bank select, active low |
| addr | input | 14 | CPU address bits 13..0 |
| rd | input | 1 | Read strobe, high for a read cycle |
| rfsh_n | input | 1 | CPU refresh strobe, active low |
| mreq_n | input | 1 | CPU memory request, active low |
| ma | output | 7 | Multiplexed DRAM address |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
If the first flop is stuck or sets early, the wrong half of the address shows on ma in PH_ROW or PH_COL within one CPU-clock period of the select falling. If the second flop is wrong, cas_n falls one double-rate edge too early or too late, or it survives a select release. A broken async clear leaves cas_n low or ma on the column half right after sel_n rises, and that is visible in the same time step. A mistake in the refresh decode shows as a missing row strobe, or a stray column strobe, while rfsh_n and mreq_n are low.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ROW  = 2'd1,
        PH_COL  = 2'd2,
        PH_CAS  = 2'd3
    } dram_phase_t;
endpackage

// File: rtl/dram_clr_ff.sv
// Rising-edge flop with an asynchronous, level-held clear.
module dram_clr_ff (
    input  logic clk,
    input  logic clr,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk or posedge clr) begin
        if (clr) q <= 1'b0;
        else     q <= d;
    end
endmodule

// File: rtl/dram_addr_mux.sv
// Picks the row half or the column half of the CPU address.
module dram_addr_mux #(
    parameter int ROW_W = 7
) (
    input  logic [2*ROW_W-1:0] addr,
    input  logic               col_sel,
    output logic [ROW_W-1:0]   ma
);
    always_comb begin
        if (col_sel) ma = addr[2*ROW_W-1:ROW_W];
        else         ma = addr[ROW_W-1:0];
    end
endmodule

// File: rtl/dram_ras_cas_seq.sv
module dram_ras_cas_seq #(
    parameter int ROW_W  = 7,
    localparam int ADDR_W = 2 * ROW_W
) (
    input  logic              clk,
    input  logic              clk2x,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              rfsh_n,
    input  logic              mreq_n,
    output logic [ROW_W-1:0]  ma,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n
);
    import dram_seq_pkg::*;

    logic        hold_clr;
    logic        ph_col_q;
    logic        ph_cas_q;
    logic        col_sel;
    logic        refresh;
    dram_phase_t phase;

    // Both phase flops stay clear while the bank is deselected or in reset.
    assign hold_clr = sel_n | ~rst_n;
    assign refresh  = ~rfsh_n & ~mreq_n;

    dram_clr_ff u_col_ff (
        .clk (clk),
        .clr (hold_clr),
        .d   (1'b1),
        .q   (ph_col_q)
    );

    dram_clr_ff u_cas_ff (
        .clk (clk2x),
        .clr (hold_clr),
        .d   (ph_col_q),
        .q   (ph_cas_q)
    );

    // Phase decode from the flops and the select.
    always_comb begin
        if (ph_cas_q)      phase = PH_CAS;
        else if (ph_col_q) phase = PH_COL;
        else if (!sel_n)   phase = PH_ROW;
        else               phase = PH_IDLE;
    end

    // Strobes and mux control per phase.
    always_comb begin
        ras_n   = 1'b1;
        cas_n   = 1'b1;
        col_sel = 1'b0;
        unique case (phase)
            PH_IDLE: ras_n = ~refresh;
            PH_ROW:  ras_n = 1'b0;
            PH_COL: begin
                ras_n   = 1'b0;
                col_sel = 1'b1;
            end
            PH_CAS: begin
                ras_n   = 1'b0;
                cas_n   = 1'b0;
                col_sel = 1'b1;
            end
            default: ;
        endcase
    end

    dram_addr_mux #(.ROW_W(ROW_W)) u_mux (
        .addr    (addr),
        .col_sel (col_sel),
        .ma      (ma)
    );

    assign we_n = rd;
endmodule

// File: rtl/dram_ras_cas_chk.sv
module dram_ras_cas_chk #(
    parameter int ROW_W  = 7,
    localparam int ADDR_W = 2 * ROW_W
) (
    input logic              clk2x,
    input logic              rst_n,
    input logic              sel_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rfsh_n,
    input logic              mreq_n,
    input logic [ROW_W-1:0]  ma,
    input logic              ras_n,
    input logic              cas_n
);
    // R9
    a_r9_cas_needs_ras: assert property (@(posedge clk2x) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    // R6
    a_r6_deselect_ends_cas: assert property (@(posedge clk2x) disable iff (!rst_n)
        sel_n |-> (cas_n && ma == addr[ROW_W-1:0]));

    // R7
    a_r7_refresh_ras_only: assert property (@(posedge clk2x) disable iff (!rst_n)
        (sel_n && !rfsh_n && !mreq_n) |-> (!ras_n && cas_n));

    // R5
    a_r5_cas_on_column: assert property (@(posedge clk2x) disable iff (!rst_n)
        !cas_n |-> ma == addr[ADDR_W-1:ROW_W]);

    // R3
    a_r3_select_gives_ras: assert property (@(posedge clk2x) disable iff (!rst_n)
        !sel_n |-> !ras_n);
endmodule

bind dram_ras_cas_seq dram_ras_cas_chk #(.ROW_W(ROW_W)) u_chk (
    .clk2x  (clk2x),
    .rst_n  (rst_n),
    .sel_n  (sel_n),
    .addr   (addr),
    .rfsh_n (rfsh_n),
    .mreq_n (mreq_n),
    .ma     (ma),
    .ras_n  (ras_n),
    .cas_n  (cas_n)
);

// File: tb/dram_ras_cas_seq_test.sv
module dram_ras_cas_seq_test;
    localparam int ROW_W = 7;

    typedef struct packed {
        logic [2*ROW_W-1:0] a;
        logic               r;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{a: 14'h0000, r: 1'b1},
        '{a: 14'h3FFF, r: 1'b0},
        '{a: 14'h2A55, r: 1'b1},
        '{a: 14'h1580, r: 1'b0},
        '{a: 14'h007F, r: 1'b1},
        '{a: 14'h3F80, r: 1'b0}
    };

    logic clk = 1'b0;
    logic clk2x = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1;
    logic [2*ROW_W-1:0] addr = '0;
    logic rd = 1'b1;
    logic rfsh_n = 1'b1;
    logic mreq_n = 1'b1;
    logic [ROW_W-1:0] ma;
    logic ras_n, cas_n, we_n;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk2x = ~clk2x;
    always @(posedge clk2x) clk <= ~clk;

    dram_ras_cas_seq #(.ROW_W(ROW_W)) uut (
        .clk(clk), .clk2x(clk2x), .rst_n(rst_n), .sel_n(sel_n),
        .addr(addr), .rd(rd), .rfsh_n(rfsh_n), .mreq_n(mreq_n),
        .ma(ma), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
    );

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_access(input logic [2*ROW_W-1:0] a, input logic r);
        @(negedge clk2x);
        addr = a;
        rd = r;
        #1;
        check(ma == a[6:0], "R2 idle row", 32'(ma), 32'(a[6:0]));
        check(we_n == r, "R8 we_n", 32'(we_n), 32'(r));
        sel_n = 1'b0;
        #1;
        check(ras_n == 1'b0, "R3 ras on select", 32'(ras_n), 0);
        check(cas_n == 1'b1 && ma == a[6:0], "R2 row phase", 32'(ma), 32'(a[6:0]));
        @(posedge clk); #1;
        check(ma == a[13:7] && cas_n == 1'b1, "R4 column mux", 32'({cas_n, ma}), 32'({1'b1, a[13:7]}));
        @(posedge clk2x); #1;
        check(cas_n == 1'b0 && ras_n == 1'b0, "R5 cas low", 32'({ras_n, cas_n}), 0);
        check(ma == a[13:7], "R5 column held", 32'(ma), 32'(a[13:7]));
        check(!(ras_n && !cas_n), "R9 cas needs ras", 32'({ras_n, cas_n}), 0);
        @(negedge clk2x);
        sel_n = 1'b1;
        #1;
        check(ras_n && cas_n && ma == a[6:0], "R6 release", 32'({ras_n, cas_n, ma}), 32'({2'b11, a[6:0]}));
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        addr = 14'h1234;
        repeat (3) @(posedge clk2x);
        #1;
        check(ras_n && cas_n && ma == 7'h34, "R1 reset state", 32'({ras_n, cas_n, ma}), 32'({2'b11, 7'h34}));
        // R1: select low during reset: RAS follows select, no CAS
        sel_n = 1'b0;
        repeat (4) @(posedge clk2x);
        #1;
        check(cas_n == 1'b1 && ma == 7'h34, "R1 flops held in reset", 32'({cas_n, ma}), 32'({1'b1, 7'h34}));
        @(negedge clk2x);
        sel_n = 1'b1;
        rst_n = 1'b1;

        foreach (VECS[i]) run_access(VECS[i].a, VECS[i].r);

        // R7: RAS-only refresh
        @(negedge clk2x);
        addr = 14'h3E5A;
        rfsh_n = 1'b0;
        mreq_n = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk2x); #1;
            check(!ras_n && cas_n && ma == 7'h5A, "R7 refresh", 32'({ras_n, cas_n, ma}), 32'({2'b01, 7'h5A}));
        end
        @(negedge clk2x);
        rfsh_n = 1'b1;
        #1;
        check(ras_n == 1'b1, "R7 refresh end", 32'(ras_n), 1);
        mreq_n = 1'b1;

        // R10: select pulse ends before any CPU-clock edge
        @(posedge clk); #1;
        @(negedge clk2x);
        addr = 14'h2D0F;
        sel_n = 1'b0;
        #1;
        check(!ras_n && ma == 7'h0F, "R10 short select row", 32'({ras_n, ma}), 32'({1'b0, 7'h0F}));
        @(posedge clk2x); #1;
        check(cas_n && ma == 7'h0F, "R10 no cas after clk2x", 32'({cas_n, ma}), 32'({1'b1, 7'h0F}));
        @(negedge clk2x);
        sel_n = 1'b1;
        repeat (3) @(posedge clk2x);
        #1;
        check(cas_n && ras_n && ma == 7'h0F, "R10 short select end", 32'({ras_n, cas_n, ma}), 32'({2'b11, 7'h0F}));

        // R8: write enable in both directions without select
        rd = 1'b0; #1;
        check(we_n == 1'b0, "R8 write", 32'(we_n), 0);
        rd = 1'b1; #1;
        check(we_n == 1'b1, "R8 read", 32'(we_n), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule